// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block controls thirteen general-purpose pins through a small byte-wide register space. Software configures each pin through two registers. The drive register sets direction, drive style, pull control and output value. The sense register selects which input edges raise an interrupt and shows the pin's present level. The pads themselves are outside the block. It drives a value, an output enable, a pull enable and a 2-bit pull code for each pin, and it receives each pin's level.

Each pin input passes through a two-stage synchronizer. Edges are found by comparing the synchronized level with its value from the previous cycle. A qualifying edge latches a pending bit. The pending bits are kept in two status registers: the low group holds pins 0..6 and the high group holds pins 7..12. Software clears a pending bit by writing a 1 to it. Each group also has a mask register. A single registered interrupt line reports any pending bit that is not masked.

The register port is a plain synchronous strobe interface. Writes take effect at the clock edge that samples `regWrEn`. Read data appears on `regRdData` one cycle after `regRdEn` is sampled, and it holds until the next read.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every drive register reads 0x00 and every sense register has detection code 00. All status bits are 0. Mask registers read 0x7F (low group) and 0x3F (high group). `pinOe`, `pullEn` and `irqOut` are all 0.
- R2: In the drive register, bit 5 is direction (1 = output), bit 4 is drive style (1 = push-pull) and bit 0 is the value. In push-pull mode, `pinOe` equals bit 5 and `pinOut` equals bit 0.
- R3: In open-drain mode (bit 4 = 0) with bit 5 set, a value of 0 drives low (`pinOe`=1, `pinOut`=0) and a value of 1 releases the pin (`pinOe`=0).
- R4: Drive-register bit 3 appears on `pullEn[i]` and bits 2:1 appear on `pullSel[2i+1:2i]`. The drive register reads back exactly as written in bits 5:0.
- R5: Sense-register bit 0 reads the synchronized pin level, also when the pin is an output. A write to bit 0 has no effect.
- R6: Sense-register bits 2:1 select detection: 00 none, 01 falling, 10 rising, 11 both. Edges of a kind that is not selected set no status bit.
- R7: A status bit latches on a qualifying edge whether or not it is masked. A mask bit of 1 keeps that pin off `irqOut`.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If a qualifying edge and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R10: `irqOut` is a register. It goes high one cycle after any status bit that is unmasked is set, and it falls one cycle after no such bit remains.
- R11: Pins 0..6 map to bits 6:0 of the low status register (0x1A) and the low mask register (0x1C). Pins 7..12 map to bits 5:0 of 0x1B and 0x1D. Unused upper bits read as 0.
- R12: Offsets 0x00..0x0C are the drive registers and 0x0D..0x19 are the sense registers for pins 0..12. Unmapped offsets read 0. Read data appears the cycle after the read strobe and holds while no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Register offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 8 | Registered read data |
| pinIn | input | 13 | Pin levels from the pads |
| pinOut | output | 13 | Output value per pin |
| pinOe | output | 13 | Output enable per pin |
| pullEn | output | 13 | Pull enable per pin |
| pullSel | output | 26 | Two-bit pull code per pin |
| irqOut | output | 1 | Combined interrupt, active high |

## Verification
Some rules are checked by assertions on every cycle. `irqOut` must equal the previous cycle's OR of unmasked pending bits. No status bit may fall without a write to a status offset. Read data must hold between reads. The reset values are also checked. Other behaviour can only be shown by the bench scenarios: the decoding of each detection code, the result of an edge that coincides with a clear, the open-drain and push-pull drive rules, the group bit positions and the read-back of pin levels. The bench predicts each of these from the register encodings alone.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int STB_IDX_W  = 5;
  localparam int STB_DATA_W = 8;

  // Strobes from the address decoder to the datapath
  typedef struct packed {
    logic                  outWe;   // write a drive register
    logic                  inWe;    // write a sense register
    logic                  statWe;  // write-one-to-clear status
    logic                  maskWe;  // write a mask register
    logic                  rdEn;    // capture read data
    logic                  rdOut;
    logic                  rdIn;
    logic                  rdStat;
    logic                  rdMask;
    logic                  grpSel;  // 0 = low group, 1 = high group
    logic [STB_IDX_W-1:0]  idx;     // pin index
    logic [STB_DATA_W-1:0] data;
  } regStrobeT;
endpackage

// File: rtl/gpio_edge_ctrl_ctl.sv
module gpio_edge_ctrl_ctl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 13,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output regStrobeT         strobe
);
  localparam logic [ADDR_W-1:0] IN_BASE   = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] STAT_BASE = ADDR_W'(2 * NUM_PINS);
  localparam logic [ADDR_W-1:0] MASK_BASE = ADDR_W'(2 * NUM_PINS + 2);
  localparam int               MAP_END   = 2 * NUM_PINS + 4;

  logic hitOut, hitIn, hitStat, hitMask;
  logic [ADDR_W-1:0] relIn;

  always_comb begin
    hitOut  = regAddr < IN_BASE;
    hitIn   = (regAddr >= IN_BASE) && (regAddr < STAT_BASE);
    hitStat = (regAddr >= STAT_BASE) && (regAddr < MASK_BASE);
    hitMask = (regAddr >= MASK_BASE) && (32'(regAddr) < MAP_END);
    relIn   = regAddr - IN_BASE;

    strobe.outWe  = regWrEn & hitOut;
    strobe.inWe   = regWrEn & hitIn;
    strobe.statWe = regWrEn & hitStat;
    strobe.maskWe = regWrEn & hitMask;
    strobe.rdEn   = regRdEn;
    strobe.rdOut  = hitOut;
    strobe.rdIn   = hitIn;
    strobe.rdStat = hitStat;
    strobe.rdMask = hitMask;
    strobe.grpSel = hitStat ? (regAddr != STAT_BASE) : (regAddr != MASK_BASE);
    strobe.idx    = hitIn ? STB_IDX_W'(relIn) : STB_IDX_W'(regAddr);
    strobe.data   = STB_DATA_W'(regWrData);
  end
endmodule

// File: rtl/gpio_edge_ctrl_dp.sv
module gpio_edge_ctrl_dp
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS  = 13,
  parameter int GRP0_PINS = 7,
  parameter int DATA_W    = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobeT               strobe,
  input  logic [NUM_PINS-1:0]     pinIn,
  output logic [NUM_PINS-1:0]     pinOut,
  output logic [NUM_PINS-1:0]     pinOe,
  output logic [NUM_PINS-1:0]     pullEn,
  output logic [2*NUM_PINS-1:0]   pullSel,
  output logic                    irqOut,
  output logic [DATA_W-1:0]       regRdData,
  output logic [NUM_PINS-1:0]     statBits,
  output logic [NUM_PINS-1:0]     maskBits
);
  localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;
  localparam int CTL_W     = 6;

  logic [CTL_W-1:0]    outCtl [NUM_PINS];
  logic [1:0]          detSel [NUM_PINS];
  logic [NUM_PINS-1:0] syncA, syncB, prevLvl, edgeHit, clrVec;
  logic [DATA_W-1:0]   rdMux;
  logic                unusedData;

  assign unusedData = strobe.data[7];

  // Two-stage synchronizer plus one delayed copy for edge compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  // Per-pin configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_PINS; k++) begin
        outCtl[k] <= '0;
        detSel[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NUM_PINS; k++) begin
        if (strobe.outWe && strobe.idx == STB_IDX_W'(k))
          outCtl[k] <= strobe.data[CTL_W-1:0];
        if (strobe.inWe && strobe.idx == STB_IDX_W'(k))
          detSel[k] <= strobe.data[2:1];
      end
    end
  end

  // Per-pin drive and edge qualification
  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    logic dirOut, pushPull, outVal;
    assign dirOut   = outCtl[i][5];
    assign pushPull = outCtl[i][4];
    assign outVal   = outCtl[i][0];
    assign pinOe[i]  = dirOut & (pushPull | ~outVal);
    assign pinOut[i] = pushPull & outVal;
    assign pullEn[i] = outCtl[i][3];
    assign pullSel[2*i +: 2] = outCtl[i][2:1];
    assign edgeHit[i] = (detSel[i][1] & syncB[i] & ~prevLvl[i])
                      | (detSel[i][0] & ~syncB[i] & prevLvl[i]);
  end

  always_comb begin
    clrVec = '0;
    if (strobe.statWe) begin
      if (strobe.grpSel) clrVec[NUM_PINS-1:GRP0_PINS] = strobe.data[GRP1_PINS-1:0];
      else               clrVec[GRP0_PINS-1:0]        = strobe.data[GRP0_PINS-1:0];
    end
  end

  // Status (new edge wins over clear), mask and combined interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statBits <= '0;
      maskBits <= '1;
      irqOut   <= 1'b0;
    end else begin
      statBits <= (statBits & ~clrVec) | edgeHit;
      if (strobe.maskWe) begin
        if (strobe.grpSel) maskBits[NUM_PINS-1:GRP0_PINS] <= strobe.data[GRP1_PINS-1:0];
        else               maskBits[GRP0_PINS-1:0]        <= strobe.data[GRP0_PINS-1:0];
      end
      irqOut <= |(statBits & ~maskBits);
    end
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      if (strobe.idx == STB_IDX_W'(k)) begin
        if (strobe.rdOut) rdMux = DATA_W'(outCtl[k]);
        if (strobe.rdIn)  rdMux = DATA_W'({detSel[k], syncB[k]});
      end
    end
    if (strobe.rdStat)
      rdMux = strobe.grpSel ? DATA_W'(statBits[NUM_PINS-1:GRP0_PINS])
                            : DATA_W'(statBits[GRP0_PINS-1:0]);
    if (strobe.rdMask)
      rdMux = strobe.grpSel ? DATA_W'(maskBits[NUM_PINS-1:GRP0_PINS])
                            : DATA_W'(maskBits[GRP0_PINS-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            regRdData <= '0;
    else if (strobe.rdEn) regRdData <= rdMux;
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS  = 13,
  parameter int GRP0_PINS = 7,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  regRdEn,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [NUM_PINS-1:0]   pullEn,
  output logic [2*NUM_PINS-1:0] pullSel,
  output logic                  irqOut
);
  regStrobeT           strobe;
  logic [NUM_PINS-1:0] statBits, maskBits;

  gpio_edge_ctrl_ctl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .strobe(strobe)
  );

  gpio_edge_ctrl_dp #(.NUM_PINS(NUM_PINS), .GRP0_PINS(GRP0_PINS), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .pullEn(pullEn), .pullSel(pullSel),
    .irqOut(irqOut), .regRdData(regRdData),
    .statBits(statBits), .maskBits(maskBits)
  );
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NUM_PINS = 13,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrEn,
  input logic                regRdEn,
  input logic [DATA_W-1:0]   regRdData,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] pullEn,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] statBits,
  input logic [NUM_PINS-1:0] maskBits
);
  localparam logic [ADDR_W-1:0] STAT_LO = ADDR_W'(2 * NUM_PINS);
  localparam logic [ADDR_W-1:0] STAT_HI = ADDR_W'(2 * NUM_PINS + 1);

  // R1: reset drives outputs and state to their idle values
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (pinOe == '0 && pullEn == '0 && !irqOut && statBits == '0 && maskBits == '1));

  // R10: interrupt register follows unmasked pending bits with one cycle of delay
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> irqOut == $past(|(statBits & ~maskBits)));

  // R8: a pending bit only falls after a write to a status offset
  assert_no_silent_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && (regAddr == STAT_LO || regAddr == STAT_HI)) |=>
      (($past(statBits) & ~statBits) == '0));

  // R12: read data holds while no read is issued
  assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regRdData(regRdData), .pinOe(pinOe), .pullEn(pullEn), .irqOut(irqOut),
  .statBits(statBits), .maskBits(maskBits)
);

// File: tb/gpio_edge_ctrl_test.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regRdData;
  logic [12:0] pinIn = '0;
  logic [12:0] pinOut, pinOe, pullEn;
  logic [25:0] pullSel;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_ctrl uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .pullEn(pullEn),
    .pullSel(pullSel), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Driver: issue a read and push the expected byte
  task automatic rdExp(input logic [4:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic setPin(input int p, input logic v);
    @(negedge clk);
    pinIn[p] = v;
    repeat (5) @(negedge clk);
  endtask

  // Monitor: compare read data the cycle after each sampled strobe
  always @(posedge clk) rdSeen <= regRdEn;
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      check(tagQ.pop_front(), 32'(regRdData), 32'(expQ.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pinOe", 32'(pinOe), 0);
    check("R1 pullEn", 32'(pullEn), 0);
    check("R1 irqOut", 32'(irqOut), 0);
    rdExp(5'h1C, 8'h7F, "R1 mask low");
    rdExp(5'h1D, 8'h3F, "R1 mask high");
    rdExp(5'h1A, 8'h00, "R1 status low");
    rdExp(5'h0D, 8'h00, "R1 sense pin0");
    rdExp(5'h07, 8'h00, "R1 drive pin7");

    // R6 rising detection on pin 2 (low group bit 2)
    wr(5'h0F, 8'h04);
    setPin(2, 1'b1);
    rdExp(5'h1A, 8'h04, "R6 rising sets status");
    rdExp(5'h0F, 8'h05, "R5 sense level and code");
    check("R7 masked pending keeps irq low", 32'(irqOut), 0);

    // R10 latency after unmask
    wr(5'h1C, 8'h7B);
    check("R10 irq not yet high", 32'(irqOut), 0);
    @(negedge clk);
    check("R10 irq high one cycle later", 32'(irqOut), 1);

    // R8 write-one-to-clear
    wr(5'h1A, 8'h00);
    rdExp(5'h1A, 8'h04, "R8 zero write keeps bit");
    wr(5'h1A, 8'h04);
    @(negedge clk);
    check("R10 irq falls after clear", 32'(irqOut), 0);
    rdExp(5'h1A, 8'h00, "R8 one write clears bit");

    // R6 falling edge on rising-only pin sets nothing
    setPin(2, 1'b0);
    rdExp(5'h1A, 8'h00, "R6 falling ignored on rising code");

    // R6/R11 falling-only on pin 9 (high group bit 2)
    wr(5'h16, 8'h02);
    setPin(9, 1'b1);
    rdExp(5'h1B, 8'h00, "R6 rising ignored on falling code");
    setPin(9, 1'b0);
    rdExp(5'h1B, 8'h04, "R11 pin9 in high group bit2");
    check("R7 high group masked", 32'(irqOut), 0);
    wr(5'h1B, 8'h04);

    // R6/R11 both edges on pin 12 (high group bit 5)
    wr(5'h19, 8'h06);
    setPin(12, 1'b1);
    rdExp(5'h1B, 8'h20, "R6 both code rising");
    wr(5'h1B, 8'h20);
    setPin(12, 1'b0);
    rdExp(5'h1B, 8'h20, "R6 both code falling");
    wr(5'h1B, 8'h20);
    rdExp(5'h19, 8'h06, "R12 last sense offset");

    // R6 detection disabled on pin 0
    setPin(0, 1'b1);
    setPin(0, 1'b0);
    rdExp(5'h1A, 8'h00, "R6 code 00 sets nothing");

    // R9 edge coinciding with a clear keeps the bit set
    wr(5'h0F, 8'h06);
    setPin(2, 1'b1);
    rdExp(5'h1A, 8'h04, "R9 setup pending");
    @(negedge clk);
    pinIn[2] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    regAddr = 5'h1A; regWrData = 8'h04; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rdExp(5'h1A, 8'h04, "R9 edge wins over clear");
    wr(5'h1A, 8'h04);
    rdExp(5'h1A, 8'h00, "R9 later clear works");

    // R11 unused mask bits
    wr(5'h1C, 8'hFF);
    rdExp(5'h1C, 8'h7F, "R11 low mask width");
    wr(5'h1D, 8'hFF);
    rdExp(5'h1D, 8'h3F, "R11 high mask width");

    // R5 write to level bit ignored
    wr(5'h11, 8'h01);
    rdExp(5'h11, 8'h00, "R5 level bit not writable");

    // R2/R4 push-pull drive and readback
    wr(5'h03, 8'h31);
    check("R2 pushpull high out", 32'(pinOut[3]), 1);
    check("R2 pushpull high oe", 32'(pinOe[3]), 1);
    rdExp(5'h03, 8'h31, "R4 drive readback");
    setPin(3, 1'b1);
    rdExp(5'h10, 8'h01, "R5 level read while output");
    wr(5'h03, 8'h30);
    check("R2 pushpull low out", 32'(pinOut[3]), 0);
    check("R2 pushpull low oe", 32'(pinOe[3]), 1);
    wr(5'h06, 8'h11);
    check("R2 input dir no drive", 32'(pinOe[6]), 0);

    // R3 open-drain
    wr(5'h04, 8'h21);
    check("R3 opendrain release", 32'(pinOe[4]), 0);
    wr(5'h04, 8'h20);
    check("R3 opendrain low oe", 32'(pinOe[4]), 1);
    check("R3 opendrain low out", 32'(pinOut[4]), 0);

    // R4 pull controls
    wr(5'h05, 8'h0E);
    check("R4 pull enable", 32'(pullEn[5]), 1);
    check("R4 pull code", 32'(pullSel[11:10]), 3);
    wr(5'h05, 8'h02);
    check("R4 pull disabled", 32'(pullEn[5]), 0);
    check("R4 pull code strong up", 32'(pullSel[11:10]), 1);

    // R12 unmapped offsets
    rdExp(5'h1E, 8'h00, "R12 unmapped 0x1E");
    rdExp(5'h1F, 8'h00, "R12 unmapped 0x1F");

    repeat (3) @(negedge clk);
    check("R12 scoreboard drained", 32'(expQ.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule